// File: doc/BRIEF.md
# Six-Level Priority Interrupt Controller

This block arbitrates six prioritized interrupt levels for a small 16-bit word-addressed processor. Level 0 has the highest priority and level 5 the lowest. Devices raise requests per level. The controller offers the winning level to the core together with the memory word address that holds that level's handler address. The vector words sit at fixed low memory, one word per level starting at word 8. When the core accepts the entry, the level is marked in service. Every level numerically equal to or below the highest level in service is then held off, but a more urgent level may still nest on top.

Levels 1 to 5 are shared by several devices and are level-sensitive: a request counts only while it is held. Level 0 carries one event per card column, so it is captured on the rising edge and stays pending until the core enters it. A second column event that arrives before the first has been entered sets a sticky overrun flag, which software clears explicitly. The core leaves a level by executing a long-format branch-or-skip instruction with its exit bit set. The controller watches the executed instruction word and clears the most urgent level in service. A fast-cycle indication is driven while level 0 or level 1 is in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `ent_req`, `in_service`, `fast_mode` and `ovr_flag` all zero.
- R2: Suppose a level n is pending and n is numerically below every level in service. Then `ent_req` is high after the next clock edge, with `ent_level` = n and `ent_vec` = 8 + n. When several levels are eligible, the lowest-numbered one wins.
- R3: No entry is requested for a level that is numerically equal to or greater than the lowest-numbered bit set in `in_service`, even while that level is pending.
- R4: An `ent_ack` sampled while `ent_req` is high sets bit `ent_level` of `in_service` at that edge, and the same edge withdraws the request for that level. An `ent_ack` sampled while `ent_req` is low has no effect.
- R5: A more urgent level is requested, and can be entered, while a less urgent level is in service, so that several bits of `in_service` are set at once.
- R6: An exit is decoded when all of the following hold: `exec_valid` is high, `exec_word[15:11]` equals 5'b01001, the format bit `exec_word[10]` is 1 (long form) and the exit bit `exec_word[6]` is 1. An exit clears the lowest-numbered set bit of `in_service` at that edge. Any other word, a short-format word, a word with bit 6 clear, or an exit while nothing is in service leaves `in_service` unchanged.
- R7: `fast_mode` is high exactly when bit 0 or bit 1 of `in_service` is set, and it changes in the same cycle as `in_service`.
- R8: A rising edge of `irq_req[0]` makes level 0 pending. It stays pending after `irq_req[0]` falls, and only its entry (R4 with `ent_level` = 0) clears it.
- R9: A rising edge of `irq_req[0]` while level 0 is already pending and not being entered in that same cycle sets `ovr_flag`. The flag stays set until `ovr_clr` is sampled high. A new overrun in the same cycle as `ovr_clr` leaves the flag set.
- R10: Levels 1 to 5 are pending only while their `irq_req` bit is high. A request dropped before entry removes `ent_req` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 6 | Request per level, bit n for level n |
| ent_ack | input | 1 | Core accepts the offered entry (one cycle) |
| exec_valid | input | 1 | `exec_word` holds an instruction executed this cycle |
| exec_word | input | 16 | First word of the executed instruction |
| ovr_clr | input | 1 | Software clear of the level-0 overrun flag |
| ent_req | output | 1 | An entry is offered to the core |
| ent_level | output | 3 | Level being offered |
| ent_vec | output | 16 | Word address of the offered level's vector |
| in_service | output | 6 | In-service vector, bit n for level n |
| fast_mode | output | 1 | Fast cycle time requested |
| ovr_flag | output | 1 | Sticky level-0 overrun |

## Verification
On every cycle, the assertions check these properties. The offered vector matches the offered level, and no offer is made at or below the most urgent level in service. An accepted entry sets its bit. An exit removes exactly one bit, and `in_service` changes for no other reason. The fast indication tracks the two top levels, and the overrun flag only falls through a clear. Only the bench scenarios show the rest: which level wins among simultaneous requests, nesting order, the rejection of near-miss exit words, the hold of a level-0 event after its request drops, when an overrun is raised, and set-over-clear priority.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int unsigned PIC_DEF_LEVELS = 6;
  localparam int unsigned PIC_DEF_WORD_W = 16;
  localparam int unsigned PIC_OP_W       = 5;

  // Index of the lowest set bit, or 32 when none is set.
  function automatic int lowest_set(input logic [31:0] v);
    int idx;
    idx = 32;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
  parameter int unsigned NUM_LEVELS = pic_pkg::PIC_DEF_LEVELS,
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic                  ack_fire,
  input  logic [LVL_W-1:0]      ack_level,
  input  logic                  ovr_clr,
  output logic [NUM_LEVELS-1:0] pend_nxt,
  output logic                  ovr_flag
);

  logic irq0_prev;
  logic pend0_q;
  logic ovr_q;
  logic rise0;
  logic ack0;
  logic pend0_n;
  logic ovr_set;

  assign rise0   = irq_req[0] & ~irq0_prev;
  assign ack0    = ack_fire && (ack_level == '0);
  assign pend0_n = rise0 | (pend0_q & ~ack0);
  assign ovr_set = rise0 & pend0_q & ~ack0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_prev <= 1'b0;
      pend0_q   <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      irq0_prev <= irq_req[0];
      pend0_q   <= pend0_n;
      ovr_q     <= ovr_set | (ovr_q & ~ovr_clr);
    end
  end

  // Level 0 is edge-captured; the shared levels follow their request lines.
  generate
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_pend
      if (i == 0) begin : g_edge
        assign pend_nxt[i] = pend0_n;
      end else begin : g_level
        assign pend_nxt[i] = irq_req[i];
      end
    end
  endgenerate

  assign ovr_flag = ovr_q;

endmodule

// File: rtl/pic_isr_track.sv
module pic_isr_track #(
  parameter int unsigned NUM_LEVELS  = pic_pkg::PIC_DEF_LEVELS,
  parameter int unsigned FAST_LEVELS = 2,
  parameter int unsigned WORD_W      = pic_pkg::PIC_DEF_WORD_W,
  parameter logic [pic_pkg::PIC_OP_W-1:0] EXIT_OP = 5'b01001,
  localparam int unsigned LVL_W   = $clog2(NUM_LEVELS),
  localparam int unsigned OP_W    = pic_pkg::PIC_OP_W,
  localparam int unsigned FMT_BIT = WORD_W - 6,
  localparam int unsigned EXT_BIT = WORD_W - 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ack_fire,
  input  logic [LVL_W-1:0]      ack_level,
  input  logic                  exec_valid,
  input  logic [WORD_W-1:0]     exec_word,
  output logic [NUM_LEVELS-1:0] isr_q,
  output logic [NUM_LEVELS-1:0] isr_nxt,
  output logic                  fast_mode
);

  logic [NUM_LEVELS-1:0] above;
  logic [NUM_LEVELS-1:0] low_hot;
  logic [NUM_LEVELS-1:0] set_hot;
  logic                  exit_hit;
  logic                  fast_q;
  logic                  unused_word_bits;

  assign exit_hit = exec_valid
                 && (exec_word[WORD_W-1 -: OP_W] == EXIT_OP)
                 && exec_word[FMT_BIT]
                 && exec_word[EXT_BIT];

  assign unused_word_bits = ^exec_word;

  generate
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
      if (i == 0) begin : g_top
        assign above[i] = 1'b0;
      end else begin : g_rest
        assign above[i] = above[i-1] | isr_q[i-1];
      end
      assign low_hot[i] = isr_q[i] & ~above[i];
      assign set_hot[i] = ack_fire && (ack_level == LVL_W'(i));
    end
  endgenerate

  assign isr_nxt = (isr_q & ~(exit_hit ? low_hot : '0)) | set_hot;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      isr_q  <= isr_nxt;
      fast_q <= |isr_nxt[FAST_LEVELS-1:0];
    end
  end

  assign fast_mode = fast_q;

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned NUM_LEVELS = pic_pkg::PIC_DEF_LEVELS,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 8,
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] pend_nxt,
  input  logic [NUM_LEVELS-1:0] isr_nxt,
  output logic                  ent_req,
  output logic [LVL_W-1:0]      ent_level,
  output logic [ADDR_W-1:0]     ent_vec
);

  logic [NUM_LEVELS-1:0] blk;
  logic [NUM_LEVELS-1:0] cand;
  logic [NUM_LEVELS-1:0] seen;
  logic [NUM_LEVELS-1:0] gnt;
  logic [LVL_W-1:0]      win_lvl;

  logic              req_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [ADDR_W-1:0] vec_q;

  generate
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign blk[i]  = isr_nxt[i];
        assign seen[i] = cand[i];
        assign gnt[i]  = cand[i];
      end else begin : g_next
        assign blk[i]  = blk[i-1] | isr_nxt[i];
        assign seen[i] = seen[i-1] | cand[i];
        assign gnt[i]  = cand[i] & ~seen[i-1];
      end
      assign cand[i] = pend_nxt[i] & ~blk[i];
    end
  endgenerate

  always_comb begin
    win_lvl = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (gnt[i]) win_lvl = win_lvl | LVL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      lvl_q <= '0;
      vec_q <= ADDR_W'(VEC_BASE);
    end else begin
      req_q <= |cand;
      lvl_q <= win_lvl;
      vec_q <= ADDR_W'(VEC_BASE) + ADDR_W'(win_lvl);
    end
  end

  assign ent_req   = req_q;
  assign ent_level = lvl_q;
  assign ent_vec   = vec_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM_LEVELS  = pic_pkg::PIC_DEF_LEVELS,
  parameter int unsigned FAST_LEVELS = 2,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned VEC_BASE    = 8,
  parameter int unsigned WORD_W      = pic_pkg::PIC_DEF_WORD_W,
  parameter logic [pic_pkg::PIC_OP_W-1:0] EXIT_OP = 5'b01001,
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic                  ent_ack,
  input  logic                  exec_valid,
  input  logic [WORD_W-1:0]     exec_word,
  input  logic                  ovr_clr,
  output logic                  ent_req,
  output logic [LVL_W-1:0]      ent_level,
  output logic [ADDR_W-1:0]     ent_vec,
  output logic [NUM_LEVELS-1:0] in_service,
  output logic                  fast_mode,
  output logic                  ovr_flag
);

  logic                  ack_fire;
  logic [NUM_LEVELS-1:0] pend_nxt;
  logic [NUM_LEVELS-1:0] isr_nxt;

  assign ack_fire = ent_ack & ent_req;

  pic_req_capture #(.NUM_LEVELS(NUM_LEVELS)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .ack_fire  (ack_fire),
    .ack_level (ent_level),
    .ovr_clr   (ovr_clr),
    .pend_nxt  (pend_nxt),
    .ovr_flag  (ovr_flag)
  );

  pic_isr_track #(
    .NUM_LEVELS (NUM_LEVELS),
    .FAST_LEVELS(FAST_LEVELS),
    .WORD_W     (WORD_W),
    .EXIT_OP    (EXIT_OP)
  ) u_isr (
    .clk        (clk),
    .rst        (rst),
    .ack_fire   (ack_fire),
    .ack_level  (ent_level),
    .exec_valid (exec_valid),
    .exec_word  (exec_word),
    .isr_q      (in_service),
    .isr_nxt    (isr_nxt),
    .fast_mode  (fast_mode)
  );

  pic_arbiter #(
    .NUM_LEVELS(NUM_LEVELS),
    .ADDR_W    (ADDR_W),
    .VEC_BASE  (VEC_BASE)
  ) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend_nxt  (pend_nxt),
    .isr_nxt   (isr_nxt),
    .ent_req   (ent_req),
    .ent_level (ent_level),
    .ent_vec   (ent_vec)
  );

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int unsigned NUM_LEVELS  = 6,
  parameter int unsigned FAST_LEVELS = 2,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned VEC_BASE    = 8,
  parameter int unsigned WORD_W      = 16,
  parameter logic [4:0]  EXIT_OP     = 5'b01001,
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ent_ack,
  input logic                  exec_valid,
  input logic [WORD_W-1:0]     exec_word,
  input logic                  ovr_clr,
  input logic                  ent_req,
  input logic [LVL_W-1:0]      ent_level,
  input logic [ADDR_W-1:0]     ent_vec,
  input logic [NUM_LEVELS-1:0] in_service,
  input logic                  fast_mode,
  input logic                  ovr_flag
);

  logic is_exit;
  logic took;

  assign is_exit = exec_valid && (exec_word[WORD_W-1 -: 5] == EXIT_OP)
                && exec_word[WORD_W-6] && exec_word[WORD_W-10];
  assign took    = ent_req && ent_ack;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!ent_req && in_service == '0 && !fast_mode && !ovr_flag));

  a_r2_vector_addr: assert property (@(posedge clk) disable iff (rst)
    ent_req |-> (ent_vec == ADDR_W'(VEC_BASE) + ADDR_W'(ent_level)));

  a_r3_no_lower_offer: assert property (@(posedge clk) disable iff (rst)
    (ent_req && in_service != '0) |->
      (int'(ent_level) < pic_pkg::lowest_set(32'(in_service))));

  a_r4_ack_sets: assert property (@(posedge clk) disable iff (rst)
    (took && !is_exit) |=> in_service[$past(ent_level)]);

  a_r6_exit_one: assert property (@(posedge clk) disable iff (rst)
    (is_exit && !took && in_service != '0) |=>
      ($countones(in_service) == $countones($past(in_service)) - 1));

  a_r6_no_stray_change: assert property (@(posedge clk) disable iff (rst)
    (!is_exit && !took) |=> $stable(in_service));

  a_r7_fast_tracks: assert property (@(posedge clk) disable iff (rst)
    fast_mode == (|in_service[FAST_LEVELS-1:0]));

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

endmodule

bind prio_irq_ctrl pic_checker #(
  .NUM_LEVELS (NUM_LEVELS),
  .FAST_LEVELS(FAST_LEVELS),
  .ADDR_W     (ADDR_W),
  .VEC_BASE   (VEC_BASE),
  .WORD_W     (WORD_W),
  .EXIT_OP    (EXIT_OP)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ent_ack    (ent_ack),
  .exec_valid (exec_valid),
  .exec_word  (exec_word),
  .ovr_clr    (ovr_clr),
  .ent_req    (ent_req),
  .ent_level  (ent_level),
  .ent_vec    (ent_vec),
  .in_service (in_service),
  .fast_mode  (fast_mode),
  .ovr_flag   (ovr_flag)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  irq_req;
  logic        ent_ack;
  logic        exec_valid;
  logic [15:0] exec_word;
  logic        ovr_clr;
  logic        ent_req;
  logic [2:0]  ent_level;
  logic [15:0] ent_vec;
  logic [5:0]  in_service;
  logic        fast_mode;
  logic        ovr_flag;

  typedef struct {
    string      tag;
    logic       req;
    int         lvl;
    logic [5:0] isr;
    logic       fast;
    logic       ovr;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .ent_ack(ent_ack),
    .exec_valid(exec_valid), .exec_word(exec_word), .ovr_clr(ovr_clr),
    .ent_req(ent_req), .ent_level(ent_level), .ent_vec(ent_vec),
    .in_service(in_service), .fast_mode(fast_mode), .ovr_flag(ovr_flag)
  );

  localparam logic [15:0] W_EXIT   = 16'h4C40; // long form, exit bit set
  localparam logic [15:0] W_SHORT  = 16'h4840; // format bit clear
  localparam logic [15:0] W_NOEXIT = 16'h4C00; // exit bit clear
  localparam logic [15:0] W_OTHOP  = 16'h5440; // different opcode

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_st(string tag, logic req, int lvl, logic [5:0] isr,
                           logic fast, logic ovr);
    exp_t e;
    e.tag = tag; e.req = req; e.lvl = lvl; e.isr = isr; e.fast = fast; e.ovr = ovr;
    exp_q.push_back(e);
  endtask

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compares queued expectations away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "ent_req", int'(ent_req), int'(e.req));
        if (e.req) begin
          cmp(e.tag, "ent_level", int'(ent_level), e.lvl);
          cmp(e.tag, "ent_vec", int'(ent_vec), 8 + e.lvl);
        end
        cmp(e.tag, "in_service", int'(in_service), int'(e.isr));
        cmp(e.tag, "fast_mode", int'(fast_mode), int'(e.fast));
        cmp(e.tag, "ovr_flag", int'(ovr_flag), int'(e.ovr));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_cmp++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; irq_req = '0; ent_ack = 0; exec_valid = 0; exec_word = '0; ovr_clr = 0;
    tick(); tick();
    rst = 1'b0;
    tick();
    expect_st("R1 reset", 0, 0, 6'b000000, 0, 0);

    irq_req = 6'b101000; tick();
    expect_st("R2 lowest wins", 1, 3, 6'b000000, 0, 0);

    ent_ack = 1; tick(); ent_ack = 0;
    expect_st("R4 ack sets R3 blocks", 0, 0, 6'b001000, 0, 0);

    ent_ack = 1; tick(); ent_ack = 0;
    expect_st("R4 ack ignored", 0, 0, 6'b001000, 0, 0);

    irq_req = 6'b101010; tick();
    expect_st("R5 preempt offer", 1, 1, 6'b001000, 0, 0);

    ent_ack = 1; tick(); ent_ack = 0;
    expect_st("R5 nested R7 fast", 0, 0, 6'b001010, 1, 0);

    exec_valid = 1; exec_word = W_SHORT; tick();
    expect_st("R6 short ignored", 0, 0, 6'b001010, 1, 0);
    exec_word = W_NOEXIT; tick();
    expect_st("R6 bit6 ignored", 0, 0, 6'b001010, 1, 0);
    exec_word = W_OTHOP; tick();
    expect_st("R6 opcode ignored", 0, 0, 6'b001010, 1, 0);

    irq_req = 6'b101000; exec_word = W_EXIT; tick();
    expect_st("R6 exit top R7 slow", 0, 0, 6'b001000, 0, 0);

    irq_req = 6'b100000; tick();
    exec_valid = 0;
    expect_st("R6 exit last R2 next", 1, 5, 6'b000000, 0, 0);

    irq_req = 6'b000000; tick();
    expect_st("R10 dropped", 0, 0, 6'b000000, 0, 0);

    irq_req = 6'b000001; tick();
    expect_st("R8 capture", 1, 0, 6'b000000, 0, 0);
    irq_req = 6'b000000; tick();
    expect_st("R8 held", 1, 0, 6'b000000, 0, 0);
    irq_req = 6'b000001; tick();
    expect_st("R9 overrun", 1, 0, 6'b000000, 0, 1);

    irq_req = 6'b000000; ent_ack = 1; tick(); ent_ack = 0;
    expect_st("R8 entered R7", 0, 0, 6'b000001, 1, 1);

    ovr_clr = 1; tick(); ovr_clr = 0;
    expect_st("R9 clear", 0, 0, 6'b000001, 1, 0);

    irq_req = 6'b000001; tick();
    expect_st("R3 self block", 0, 0, 6'b000001, 1, 0);
    irq_req = 6'b000000; tick();
    irq_req = 6'b000001; ovr_clr = 1; tick(); ovr_clr = 0; irq_req = 6'b000000;
    expect_st("R9 set wins", 0, 0, 6'b000001, 1, 1);

    exec_valid = 1; exec_word = W_EXIT; tick(); exec_valid = 0;
    expect_st("R6 exit R8 pending", 1, 0, 6'b000000, 0, 1);

    ent_ack = 1; tick(); ent_ack = 0;
    expect_st("R4 enter level0", 0, 0, 6'b000001, 1, 1);

    exec_valid = 1; tick();
    expect_st("R6 exit level0", 0, 0, 6'b000000, 0, 1);
    tick(); exec_valid = 0;
    expect_st("R6 exit empty", 0, 0, 6'b000000, 0, 1);

    ovr_clr = 1; tick(); ovr_clr = 0;
    expect_st("R9 clear again", 0, 0, 6'b000000, 0, 0);

    tick(); tick();
    finish_run();
  end

endmodule